// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block sits between a local bus and a PCI host interface. It turns a 32-bit local-bus address into a PCI bus address. It does this with three programmable windows, and each window is described by a BASE word and a MAP word.

- **Windows 0 and 1** cover a power-of-two span between 1 MB and 2 MB << 10. They produce whatever memory-class cycle type the MAP word names.
- **Window 2** is a fixed 16 MB aperture. It always produces PCI I/O cycles.

For every translation request the block returns one cycle later:
- a hit flag and a miss flag,
- the index of the window used,
- the translated PCI address,
- the encoded PCI cycle type,
- a prefetch flag.

Windows may overlap. They are searched in ascending index order and the first enabled window that covers the address wins. Software can therefore enlarge window 0 to hide window 1 while window 1 is being reprogrammed, for example to point it at configuration space.

The register port writes and reads the six words. The byte-swap fields are stored and read back, but they have no effect on translation.

Top module: `lpci_xlate`

## Requirements
- R1: After a synchronous reset all six registers read as zero and every translation output is zero.
- R2: Register index (`reg_addr`) encoding: 0 = BASE0, 1 = MAP0, 2 = BASE1, 3 = MAP1, 4 = BASE2, 5 = MAP2. Indices 6 and 7 read as zero and ignore writes. `reg_rdata` shows the word selected in the previous cycle.
- R3: BASE0/BASE1 field layout: local base bits 31:20 in bits 31:20, swap in 9:8, size code in 7:4, prefetch in bit 3, enable in bit 0. All other bits read as zero.
- R4: MAP0/MAP1 field layout: PCI base bits 31:20 in bits 15:4, cycle type in 3:1, low-address pass enable in bit 0. Bits 31:16 read as zero.
- R5: Window-2 field layout. BASE2 holds local bits 31:24 in bits 15:8, swap in 7:6 and enable in bit 0. MAP2 holds PCI bits 31:24 in bits 15:8. All other bits of both words read as zero.
- R6: A memory window with size code n (0..11) covers 1 MB << n. It matches when the local address bits at and above bit 20+n equal the same bits of its base.
- R7: A memory window with size code 12..15 never matches, and any window whose enable bit is 0 never matches.
- R8: Windows are checked in the order 0, 1, 2, and the first match is used. `out_win` reports its index.
- R9: For a memory-window hit, the PCI address bits at and above bit 20+n come from MAP, and the offset bits below them come from the local address.
- R10: For a memory-window hit, bits 1:0 of the PCI address are 00 when the low-address pass enable is 0, and are copied from the local address when it is 1.
- R11: A memory-window hit outputs the MAP cycle type and the BASE prefetch bit. Cycle type codes: 000 interrupt ack, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple.
- R12: A window-2 hit outputs cycle type 001, prefetch 0, and the PCI address {MAP2 bits 15:8, local bits 23:0}.
- R13: When no window matches, `out_miss` is 1 and `out_hit` is 0, and the PCI address, cycle type and prefetch outputs are zero. With no request, `out_valid`, `out_hit` and `out_miss` are all 0.
- R14: Results appear one cycle after `xl_valid`. A register write is seen by requests presented in any later cycle. A request presented in the same cycle as a write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the word indexed last cycle |
| xl_valid | input | 1 | Translation request |
| xl_addr | input | 32 | Local-bus address to translate |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | An enabled window covered the address |
| out_miss | output | 1 | No window covered the address; no PCI cycle |
| out_win | output | 2 | Index of the window used |
| out_pci_addr | output | 32 | Translated PCI address |
| out_ctype | output | 3 | PCI cycle type code |
| out_pref | output | 1 | Prefetchable window |

## Verification
The hardest situation to reach is an overlap, where two enabled windows both cover one address and only the ascending-order rule decides the winner. The bench creates it the way software does during a configuration access: it grows window 0 to 512 MB over an already programmed window 1, translates an address inside window 1, then shrinks window 0 back and repeats the same address. The same-edge case is driven by asserting a register write and a translation request in one cycle, followed by the same request one cycle later.

// File: rtl/lpci_xlate_pkg.sv
package lpci_xlate_pkg;
  localparam int LA_W     = 32;              // local / PCI address width
  localparam int MIN_SH   = 20;              // log2 of smallest memory window
  localparam int HI_W     = LA_W - MIN_SH;   // compared upper bits
  localparam int MAX_CODE = HI_W - 1;        // largest defined size code
  localparam int IO_SH    = 24;              // log2 of the fixed I/O window
  localparam int IO_HI_W  = LA_W - IO_SH;
  localparam int CT_W     = 3;

  localparam logic [CT_W-1:0] CT_IO = 3'b001;

  typedef struct packed {
    logic [HI_W-1:0] base_hi;
    logic [3:0]      size;
    logic            pref;
    logic            en;
    logic [HI_W-1:0] map_hi;
    logic [CT_W-1:0] ctype;
    logic            adlow;
  } mem_cfg_t;

  typedef struct packed {
    logic [IO_HI_W-1:0] base_hi;
    logic               en;
    logic [IO_HI_W-1:0] map_hi;
  } io_cfg_t;

  typedef struct packed {
    logic            hit;
    logic [LA_W-1:0] pci;
    logic [CT_W-1:0] ctype;
    logic            pref;
  } win_res_t;
endpackage

// File: rtl/lpci_win_regs.sv
module lpci_win_regs
  import lpci_xlate_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  parameter int REG_W       = $clog2(2*NUM_MEM_WIN+2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] addr,
  input  logic [LA_W-1:0]  wdata,
  output logic [LA_W-1:0]  rdata,
  output mem_cfg_t         mem_cfg [NUM_MEM_WIN],
  output io_cfg_t          io_cfg
);
  localparam int IO_BASE_IDX = 2*NUM_MEM_WIN;
  localparam int IO_MAP_IDX  = 2*NUM_MEM_WIN + 1;

  mem_cfg_t   cfg_q  [NUM_MEM_WIN];
  logic [1:0] swap_q [NUM_MEM_WIN];
  io_cfg_t    io_q;
  logic [1:0] io_swap_q;

  logic wr_unused;
  assign wr_unused = ^{wdata[MIN_SH-1:10], wdata[2:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_MEM_WIN; w++) begin
        cfg_q[w]  <= '0;
        swap_q[w] <= '0;
      end
      io_q      <= '0;
      io_swap_q <= '0;
    end else if (we) begin
      for (int w = 0; w < NUM_MEM_WIN; w++) begin
        if (addr == REG_W'(2*w)) begin
          cfg_q[w].base_hi <= wdata[LA_W-1:MIN_SH];
          swap_q[w]        <= wdata[9:8];
          cfg_q[w].size    <= wdata[7:4];
          cfg_q[w].pref    <= wdata[3];
          cfg_q[w].en      <= wdata[0];
        end
        if (addr == REG_W'(2*w+1)) begin
          cfg_q[w].map_hi <= wdata[HI_W+3:4];
          cfg_q[w].ctype  <= wdata[3:1];
          cfg_q[w].adlow  <= wdata[0];
        end
      end
      if (addr == REG_W'(IO_BASE_IDX)) begin
        io_q.base_hi <= wdata[15:8];
        io_swap_q    <= wdata[7:6];
        io_q.en      <= wdata[0];
      end
      if (addr == REG_W'(IO_MAP_IDX)) io_q.map_hi <= wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      for (int w = 0; w < NUM_MEM_WIN; w++) begin
        if (addr == REG_W'(2*w))
          rdata <= {cfg_q[w].base_hi, 10'b0, swap_q[w], cfg_q[w].size,
                    cfg_q[w].pref, 2'b0, cfg_q[w].en};
        if (addr == REG_W'(2*w+1))
          rdata <= {16'b0, cfg_q[w].map_hi, cfg_q[w].ctype, cfg_q[w].adlow};
      end
      if (addr == REG_W'(IO_BASE_IDX))
        rdata <= {16'b0, io_q.base_hi, io_swap_q, 5'b0, io_q.en};
      if (addr == REG_W'(IO_MAP_IDX))
        rdata <= {16'b0, io_q.map_hi, 8'b0};
    end
  end

  assign mem_cfg = cfg_q;
  assign io_cfg  = io_q;

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr > REG_W'(IO_MAP_IDX)) |=> (rdata == '0)); // R2
endmodule

// File: rtl/lpci_mem_win.sv
module lpci_mem_win
  import lpci_xlate_pkg::*;
(
  input  logic [LA_W-1:0] addr,
  input  mem_cfg_t        cfg,
  output win_res_t        res
);
  logic [HI_W-1:0] keep_mask;
  logic            size_ok;
  logic [HI_W-1:0] pci_hi;

  always_comb begin
    size_ok   = (cfg.size <= 4'(MAX_CODE));
    keep_mask = {HI_W{1'b1}} << cfg.size;
    pci_hi    = (cfg.map_hi & keep_mask) | (addr[LA_W-1:MIN_SH] & ~keep_mask);
    res.hit   = cfg.en && size_ok &&
                (((addr[LA_W-1:MIN_SH] ^ cfg.base_hi) & keep_mask) == '0);
    res.pci   = {pci_hi, addr[MIN_SH-1:2], cfg.adlow ? addr[1:0] : 2'b00};
    res.ctype = cfg.ctype;
    res.pref  = cfg.pref;
  end
endmodule

// File: rtl/lpci_io_win.sv
module lpci_io_win
  import lpci_xlate_pkg::*;
(
  input  logic [LA_W-1:0] addr,
  input  io_cfg_t         cfg,
  output win_res_t        res
);
  always_comb begin
    res.hit   = cfg.en && (addr[LA_W-1:IO_SH] == cfg.base_hi);
    res.pci   = {cfg.map_hi, addr[IO_SH-1:0]};
    res.ctype = CT_IO;
    res.pref  = 1'b0;
  end
endmodule

// File: rtl/lpci_prio_sel.sv
module lpci_prio_sel
  import lpci_xlate_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  win_res_t         res [NUM_WIN],
  output win_res_t         sel,
  output logic [IDX_W-1:0] sel_idx
);
  always_comb begin
    sel     = '0;
    sel_idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (res[w].hit) begin
        sel     = res[w];
        sel_idx = IDX_W'(w);
      end
    end
  end
endmodule

// File: rtl/lpci_xlate.sv
module lpci_xlate
  import lpci_xlate_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  parameter int NUM_WIN     = NUM_MEM_WIN + 1,
  parameter int IDX_W       = $clog2(NUM_WIN),
  parameter int REG_W       = $clog2(2*NUM_WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_addr,
  input  logic [LA_W-1:0]  reg_wdata,
  output logic [LA_W-1:0]  reg_rdata,
  input  logic             xl_valid,
  input  logic [LA_W-1:0]  xl_addr,
  output logic             out_valid,
  output logic             out_hit,
  output logic             out_miss,
  output logic [IDX_W-1:0] out_win,
  output logic [LA_W-1:0]  out_pci_addr,
  output logic [CT_W-1:0]  out_ctype,
  output logic             out_pref
);
  mem_cfg_t         mem_cfg [NUM_MEM_WIN];
  io_cfg_t          io_cfg;
  win_res_t         res     [NUM_WIN];
  win_res_t         sel;
  logic [IDX_W-1:0] sel_idx;

  lpci_win_regs #(.NUM_MEM_WIN(NUM_MEM_WIN), .REG_W(REG_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mem_cfg(mem_cfg), .io_cfg(io_cfg)
  );

  for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
    lpci_mem_win mem_i (.addr(xl_addr), .cfg(mem_cfg[w]), .res(res[w]));
  end

  lpci_io_win io_i (.addr(xl_addr), .cfg(io_cfg), .res(res[NUM_MEM_WIN]));

  lpci_prio_sel #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) prio_i (
    .res(res), .sel(sel), .sel_idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || !xl_valid) begin
      out_valid    <= 1'b0;
      out_hit      <= 1'b0;
      out_miss     <= 1'b0;
      out_win      <= '0;
      out_pci_addr <= '0;
      out_ctype    <= '0;
      out_pref     <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_hit      <= sel.hit;
      out_miss     <= !sel.hit;
      out_win      <= sel_idx;
      out_pci_addr <= sel.pci;
      out_ctype    <= sel.ctype;
      out_pref     <= sel.pref;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> out_valid); // R14
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit != out_miss)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_hit && !out_miss); // R13
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_pci_addr == '0) && (out_ctype == '0) && !out_pref); // R13
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_pci_addr[MIN_SH-1:2] == $past(xl_addr[MIN_SH-1:2])); // R9
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (out_hit && out_win == IDX_W'(NUM_MEM_WIN)) |->
      (out_ctype == CT_IO) && !out_pref &&
      (out_pci_addr[IO_SH-1:0] == $past(xl_addr[IO_SH-1:0]))); // R12
endmodule

// File: tb/lpci_xlate_tb_top.sv
module lpci_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        xl_valid;
  logic [31:0] xl_addr;
  logic        out_valid, out_hit, out_miss, out_pref;
  logic [1:0]  out_win;
  logic [31:0] out_pci_addr;
  logic [2:0]  out_ctype;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  lpci_xlate dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_valid(xl_valid),
    .xl_addr(xl_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_miss(out_miss), .out_win(out_win), .out_pci_addr(out_pci_addr),
    .out_ctype(out_ctype), .out_pref(out_pref)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check32(req, reg_rdata, exp);
  endtask

  // packed result: {valid,hit,miss,win,ctype,pref} then pci address
  task automatic xl_check(string req, logic [31:0] a, logic hit,
                          logic [1:0] win, logic [31:0] pci,
                          logic [2:0] ct, logic pf);
    @(negedge clk);
    xl_valid = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_valid = 1'b0;
    check32({req, " flags"},
            {23'b0, out_valid, out_hit, out_miss, out_win, out_ctype, out_pref},
            {23'b0, 1'b1, hit, !hit, win, ct, pf});
    check32({req, " pci"}, out_pci_addr, pci);
  endtask

  task automatic t_reset;
    check32("R1 outputs", {out_valid, out_hit, out_miss, out_win, out_ctype,
                           out_pref, out_pci_addr[22:0]}, 32'h0);
    for (int i = 0; i < 6; i++) rd_check("R1 reg zero", 3'(i), 32'h0);
  endtask

  task automatic t_layout;
    wr(3'd0, 32'hFFFF_FFFF); rd_check("R3 BASE0 fields", 3'd0, 32'hFFF0_03F9);
    wr(3'd1, 32'hFFFF_FFFF); rd_check("R4 MAP0 fields", 3'd1, 32'h0000_FFFF);
    wr(3'd4, 32'hFFFF_FFFF); rd_check("R5 BASE2 fields", 3'd4, 32'h0000_FFC1);
    wr(3'd5, 32'hFFFF_FFFF); rd_check("R5 MAP2 fields", 3'd5, 32'h0000_FF00);
    wr(3'd6, 32'hFFFF_FFFF); rd_check("R2 index 6 zero", 3'd6, 32'h0);
    rd_check("R2 index 7 zero", 3'd7, 32'h0);
    rd_check("R2 BASE1 untouched", 3'd2, 32'h0);
  endtask

  task automatic t_program;
    wr(3'd0, 32'h4000_0081);   // 256 MB, enabled
    wr(3'd1, 32'h0000_0006);   // PCI 0, memory, low bits forced
    wr(3'd2, 32'h5000_0089);   // 256 MB, prefetch, enabled
    wr(3'd3, 32'h0000_100C);   // PCI 0x100, memory-multiple
    wr(3'd4, 32'h0000_6001);   // I/O window at 0x60
    wr(3'd5, 32'h0000_1200);   // PCI 0x12
    xl_check("R10 R11 win0", 32'h4123_4567, 1'b1, 2'd0, 32'h0123_4564, 3'b011, 1'b0);
    xl_check("R9 R11 win1", 32'h5ABC_DEF3, 1'b1, 2'd1, 32'h1ABC_DEF0, 3'b110, 1'b1);
    xl_check("R12 io win", 32'h60AB_CDEF, 1'b1, 2'd2, 32'h12AB_CDEF, 3'b001, 1'b0);
    xl_check("R13 miss", 32'h7000_0000, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
  endtask

  task automatic t_priority;
    wr(3'd2, 32'h5000_0051);   // window 1: 32 MB, no prefetch
    wr(3'd3, 32'h0000_000B);   // PCI 0, configuration, low bits passed
    wr(3'd0, 32'h4000_0091);   // window 0 grown to 512 MB
    xl_check("R8 win0 hides win1", 32'h5000_1236, 1'b1, 2'd0, 32'h1000_1234, 3'b011, 1'b0);
    wr(3'd0, 32'h4000_0081);   // shrink back
    xl_check("R8 R10 win1 revealed", 32'h5000_1236, 1'b1, 2'd1, 32'h0000_1236, 3'b101, 1'b0);
    xl_check("R6 32MB top edge", 32'h51FF_FFFF, 1'b1, 2'd1, 32'h01FF_FFFF, 3'b101, 1'b0);
    xl_check("R6 32MB past edge", 32'h5200_0000, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
  endtask

  task automatic t_sizes;
    wr(3'd0, 32'h4000_0001);   // 1 MB
    xl_check("R6 1MB inside", 32'h400F_FFFF, 1'b1, 2'd0, 32'h000F_FFFC, 3'b011, 1'b0);
    xl_check("R6 1MB outside", 32'h4010_0000, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
    wr(3'd0, 32'h8000_00B1);   // 2 GB
    xl_check("R9 2GB", 32'hFFFF_FFF0, 1'b1, 2'd0, 32'h7FFF_FFF0, 3'b011, 1'b0);
    wr(3'd0, 32'h4000_00C1);   // code 12 undefined
    xl_check("R7 size code 12", 32'h4000_0010, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
    wr(3'd0, 32'h4000_0080);   // disabled
    xl_check("R7 disabled", 32'h4000_0010, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
    wr(3'd4, 32'h0000_6000);   // I/O window disabled
    xl_check("R7 io disabled", 32'h60AB_CDEF, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
  endtask

  task automatic t_timing;
    wr(3'd0, 32'h4000_0081);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h4000_0080;
    xl_valid = 1'b1; xl_addr = 32'h4000_0100;
    @(negedge clk);
    reg_we = 1'b0; xl_valid = 1'b0;
    check32("R14 same-cycle old value", {out_valid, out_hit, out_pci_addr[30:0]},
            {1'b1, 1'b1, 31'h0000_0100});
    xl_check("R14 next request new value", 32'h4000_0100, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0);
    @(negedge clk);
    check32("R13 idle", {29'b0, out_valid, out_hit, out_miss}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    xl_valid = 1'b0; xl_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    t_program();
    t_priority();
    t_sizes();
    t_timing();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule